// File: doc/BRIEF.md
# Column Decision Serializer

This block gathers the one-bit decisions of a full row of column comparators and sends them off-chip over a set of narrow serial lanes. The column vector is cut into equal groups of neighbouring columns, and each group belongs to exactly one lane. A single shift enable moves every lane forward together. Each row therefore leaves in as many shift steps as a group has columns, and the lowest column of each group goes first.

The row register is backed by one spare row buffer. A row can be captured while the previous row is still being shifted. The shifter then starts on the waiting row in the cycle after the last bit of the current row, with no gap. If a capture arrives while the spare is occupied and the shifter is not finishing, the capture is refused and a sticky overrun flag is raised. The defaults are 1376 columns across 32 lanes, which gives 43 columns per lane.

Top module: `colser_top`

## Requirements
- R1: After reset, `sending_o`, `busy_o`, `overrun_o`, `row_start_o` and every bit of `lane_dout_o` are 0.
- R2: A capture while idle loads the row directly. From the next cycle `sending_o` is 1, and lane l presents column GROUP*l, where GROUP = NUM_COLS/NUM_LANES.
- R3: While sending, each cycle with `shift_en_i` high advances every lane by one column in ascending order. After k shifts, lane l shows column GROUP*l+k. In a cycle without `shift_en_i` the lane outputs hold.
- R4: `row_start_o` is 1 exactly while the first bit of a row is presented (no shifts taken yet on that row) and is 0 otherwise.
- R5: The GROUP-th shift of a row ends it. If no row is waiting, `sending_o` falls and all lane outputs return to 0.
- R6: A capture that arrives during sending while the spare buffer is empty is stored, and `busy_o` becomes 1. That row starts in the cycle after the current row's last shift, and `busy_o` returns to 0 when it starts.
- R7: A capture that arrives while `busy_o` is 1 and the current shift is not the last one sets `overrun_o`. The waiting row is kept unchanged and is sent in place of the refused one.
- R8: A capture that arrives in the same cycle as the last shift is accepted without overrun. If the spare is empty, the new row starts directly. If the spare is full, the waiting row starts and the new row takes the spare.
- R9: `overrun_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_i | input | 1 | Capture strobe for `col_bits_i` |
| col_bits_i | input | NUM_COLS | One decision bit per column |
| shift_en_i | input | 1 | Advance all lanes by one bit |
| lane_dout_o | output | NUM_LANES | Serial data, one bit per lane |
| row_start_o | output | 1 | First bit of a row is on the lanes |
| sending_o | output | 1 | A row is being shifted out |
| busy_o | output | 1 | Spare row buffer occupied |
| overrun_o | output | 1 | Sticky: a capture was refused |

## Verification
The in-line properties watch several things on every cycle. They check that the shift counter stays in range and steps by one per enabled shift. They check that a newly started row begins at count zero, and that the row ends after its last shift when nothing is queued. They also check that the spare buffer never changes without a write, that each lane shifts its next column down, and that the overrun flag is sticky and rises only on a capture against a full spare. Only the bench scenarios can show which column value appears on which lane at each step. They also show that the queued row follows without a gap and that a refused row never reaches the lanes. Finally, they cover the two cases of a capture landing on the last shift.

// File: rtl/colser_pkg.sv
package colser_pkg;
    localparam int unsigned COLS_DEFAULT  = 1376;
    localparam int unsigned LANES_DEFAULT = 32;

    typedef enum logic {
        SRC_CAPTURE = 1'b0,
        SRC_SPARE   = 1'b1
    } load_src_e;
endpackage

// File: rtl/colser_spare.sv
module colser_spare #(
    parameter int unsigned WIDTH = 1376
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } spare_t;

    spare_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.data = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.data;

    AST_SPARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q.data)); // R7
endmodule

// File: rtl/colser_lane.sv
module colser_lane #(
    parameter int unsigned GROUP = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [GROUP-1:0] load_bits_i,
    input  logic             shift_i,
    output logic             dout_o
);
    typedef struct packed {
        logic [GROUP-1:0] sr;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sr = load_bits_i;
        end else if (shift_i) begin
            st_d.sr = {1'b0, st_q.sr[GROUP-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.sr[0];

    generate
        if (GROUP > 1) begin : g_shift_chk
            AST_LANE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_i && !load_i) |=> (st_q.sr[0] == $past(st_q.sr[1]))); // R3
        end
    endgenerate
endmodule

// File: rtl/colser_ctrl.sv
module colser_ctrl
    import colser_pkg::*;
#(
    parameter int unsigned GROUP = 43
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_i,
    input  logic      shift_en_i,
    output logic      load_o,
    output load_src_e load_src_o,
    output logic      spare_wr_o,
    output logic      shift_o,
    output logic      active_o,
    output logic      row_start_o,
    output logic      spare_full_o,
    output logic      overrun_o
);
    localparam int unsigned CW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [CW-1:0] LAST = CW'(GROUP - 1);

    typedef struct packed {
        logic          active;
        logic          spare_full;
        logic          overrun;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  finish;
    logic  free;

    always_comb begin
        st_d        = st_q;
        finish      = st_q.active && shift_en_i && (st_q.cnt == LAST);
        free        = !st_q.active || finish;
        load_o      = free && (st_q.spare_full || cap_i);
        load_src_o  = st_q.spare_full ? SRC_SPARE : SRC_CAPTURE;
        shift_o     = st_q.active && shift_en_i;
        spare_wr_o  = cap_i && (free ? st_q.spare_full : !st_q.spare_full);

        if (free) begin
            st_d.spare_full = st_q.spare_full && cap_i;
        end else begin
            st_d.spare_full = st_q.spare_full || cap_i;
            if (cap_i && st_q.spare_full) begin
                st_d.overrun = 1'b1;
            end
        end

        if (load_o) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (finish) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (shift_o) begin
            st_d.cnt    = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o     = st_q.active;
    assign row_start_o  = st_q.active && (st_q.cnt == '0);
    assign spare_full_o = st_q.spare_full;
    assign overrun_o    = st_q.overrun;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt <= LAST)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && shift_en_i && (st_q.cnt != LAST))
            |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R3
    AST_NEW_ROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> (st_q.cnt == '0)); // R4
    AST_ROW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !cap_i && !st_q.spare_full) |=> !st_q.active); // R5
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.overrun) |-> $past(cap_i && st_q.spare_full)); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.overrun |=> st_q.overrun); // R9
endmodule

// File: rtl/colser_top.sv
module colser_top
    import colser_pkg::*;
#(
    parameter int unsigned NUM_COLS  = COLS_DEFAULT,
    parameter int unsigned NUM_LANES = LANES_DEFAULT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_i,
    input  logic [NUM_COLS-1:0]  col_bits_i,
    input  logic                 shift_en_i,
    output logic [NUM_LANES-1:0] lane_dout_o,
    output logic                 row_start_o,
    output logic                 sending_o,
    output logic                 busy_o,
    output logic                 overrun_o
);
    localparam int unsigned GROUP = NUM_COLS / NUM_LANES;

    logic                load;
    load_src_e           load_src;
    logic                spare_wr;
    logic                shift;
    logic                active;
    logic [NUM_COLS-1:0] spare_bits;

    colser_ctrl #(.GROUP(GROUP)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap_i),
        .shift_en_i  (shift_en_i),
        .load_o      (load),
        .load_src_o  (load_src),
        .spare_wr_o  (spare_wr),
        .shift_o     (shift),
        .active_o    (active),
        .row_start_o (row_start_o),
        .spare_full_o(busy_o),
        .overrun_o   (overrun_o)
    );

    colser_spare #(.WIDTH(NUM_COLS)) u_spare (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (spare_wr),
        .din_i (col_bits_i),
        .dout_o(spare_bits)
    );

    generate
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            logic [GROUP-1:0] slice;
            logic             bit_out;

            assign slice = (load_src == SRC_SPARE) ? spare_bits[l*GROUP +: GROUP]
                                                   : col_bits_i[l*GROUP +: GROUP];

            colser_lane #(.GROUP(GROUP)) u_lane (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_i     (load),
                .load_bits_i(slice),
                .shift_i    (shift),
                .dout_o     (bit_out)
            );

            assign lane_dout_o[l] = active && bit_out;
        end
    endgenerate

    assign sending_o = active;
endmodule

// File: tb/colser_top_bench.sv
module colser_top_bench;
    localparam int NC = 1376;
    localparam int NL = 32;
    localparam int G  = NC / NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap = 1'b0;
    logic [NC-1:0] col = '0;
    logic          shift_en = 1'b0;
    logic [NL-1:0] lanes;
    logic          row_start, sending, busy, overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    colser_top #(.NUM_COLS(NC), .NUM_LANES(NL)) u_colser_top (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .col_bits_i(col),
        .shift_en_i(shift_en), .lane_dout_o(lanes), .row_start_o(row_start),
        .sending_o(sending), .busy_o(busy), .overrun_o(overrun)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] make_row(input int seed);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = (((c * 31 + seed) * (seed + 3)) % 7) < 3;
        return r;
    endfunction

    function automatic logic [NL-1:0] lane_exp(input logic [NC-1:0] r, input int k);
        logic [NL-1:0] e;
        for (int l = 0; l < NL; l++) e[l] = r[l*G + k];
        return e;
    endfunction

    // Streams a full row, optionally injecting up to two captures.
    task automatic stream_row(input logic [NC-1:0] r, input int gap_at,
                              input int k1, input logic [NC-1:0] c1, input bit b1,
                              input int k2, input logic [NC-1:0] c2, input bit b2);
        for (int k = 0; k < G; k++) begin
            chk(lanes == lane_exp(r, k), "R3 lane bits", lanes, lane_exp(r, k));
            chk(row_start == (k == 0), "R4 row start", row_start, k == 0);
            chk(sending == 1'b1, "R3 sending", sending, 1);
            if (k == gap_at) begin
                step();
                chk(lanes == lane_exp(r, k), "R3 hold without shift", lanes, lane_exp(r, k));
            end
            shift_en = 1'b1;
            if (k == k1) begin cap = 1'b1; col = c1; end
            if (k == k2) begin cap = 1'b1; col = c2; end
            step();
            shift_en = 1'b0;
            cap = 1'b0;
            if (k == k1) chk(busy == b1, "R6 busy after capture", busy, b1);
            if (k == k2) chk(busy == b2, "R8 busy after capture", busy, b2);
        end
    endtask

    task automatic check_idle(input string req);
        chk(sending == 1'b0, req, sending, 0);
        chk(lanes == '0, req, lanes, 0);
        chk(row_start == 1'b0, req, row_start, 0);
    endtask

    task automatic t_reset();
        check_idle("R1 reset idle");
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    endtask

    task automatic t_single();
        logic [NC-1:0] a = make_row(1);
        cap = 1'b1; col = a;
        step();
        cap = 1'b0; col = '0;
        chk(lanes == lane_exp(a, 0), "R2 first column", lanes, lane_exp(a, 0));
        chk(busy == 1'b0, "R2 direct load", busy, 0);
        stream_row(a, 5, -1, '0, 0, -1, '0, 0);
        check_idle("R5 row end");
    endtask

    task automatic t_double();
        logic [NC-1:0] a = make_row(2);
        logic [NC-1:0] b = make_row(3);
        cap = 1'b1; col = a;
        step();
        cap = 1'b0;
        stream_row(a, -1, 10, b, 1, -1, '0, 0);
        chk(busy == 1'b0, "R6 spare drained", busy, 0);
        stream_row(b, -1, -1, '0, 0, -1, '0, 0);
        check_idle("R5 after queued row");
    endtask

    task automatic t_last_direct();
        logic [NC-1:0] a = make_row(4);
        logic [NC-1:0] b = make_row(5);
        cap = 1'b1; col = a;
        step();
        cap = 1'b0;
        stream_row(a, -1, G-1, b, 0, -1, '0, 0);
        stream_row(b, -1, -1, '0, 0, -1, '0, 0);
        check_idle("R8 direct at last");
        chk(overrun == 1'b0, "R8 no overrun", overrun, 0);
    endtask

    task automatic t_last_spare_full();
        logic [NC-1:0] a = make_row(6);
        logic [NC-1:0] b = make_row(7);
        logic [NC-1:0] c = make_row(8);
        cap = 1'b1; col = a;
        step();
        cap = 1'b0;
        stream_row(a, -1, 4, b, 1, G-1, c, 1);
        stream_row(b, -1, -1, '0, 0, -1, '0, 0);
        stream_row(c, -1, -1, '0, 0, -1, '0, 0);
        check_idle("R8 spare handoff");
        chk(overrun == 1'b0, "R8 no overrun with full spare", overrun, 0);
    endtask

    task automatic t_overrun();
        logic [NC-1:0] a = make_row(9);
        logic [NC-1:0] b = make_row(10);
        logic [NC-1:0] c = make_row(11);
        cap = 1'b1; col = a;
        step();
        cap = 1'b0;
        stream_row(a, -1, 3, b, 1, 6, c, 1);
        chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
        stream_row(b, -1, -1, '0, 0, -1, '0, 0);
        check_idle("R7 refused row not sent");
        repeat (3) step();
        chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk(overrun == 1'b0, "R9 cleared by reset", overrun, 0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_single();
        t_double();
        t_last_direct();
        t_last_spare_full();
        t_overrun();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule